// File: doc/BRIEF.md
# LIN Wake-Up Signal Controller

This block sends and recognises wake-up requests on a single-wire LIN bus whose character timing comes from a UART-style bit engine. A one-cycle software write launches a wake-up frame on the transmit line. The frame has three parts in this order: eight dominant bit times, which are the start bit and seven zero data bits of the wake-up character 0x80; one recessive stop bit; and a recessive delimiter whose length in bit times is programmable. Bit timing comes from an external baud tick that pulses once per bit period.

On the receive side the block watches the characters decoded by the bit engine and the raw receive line. Only a character whose value can come from a long dominant pulse is accepted. After that character, any number of dominant bit samples may follow, and the first recessive sample completes the request and raises a sticky wake-up flag. While a LIN frame is starting or running, the detector stays out of the way.

A protocol reset input stops the block at once. While it is held, the transmit line is forced recessive, no transfer starts, the DMA requests drop and every activity status reads idle. Software keeps the reset asserted until all four activity bits show idle.

Top module: `lin_wake_ctrl`

## Requirements
- R1: After reset, `tx_line` is 1, `wake_flag` is 0, `wake_tx_busy` is 0, both DMA requests are 0 and all four activity status bits are 0.
- R2: A 1 on `wake_trig_wr` while idle drives `tx_line` to 0 from the next clock edge. The line stays 0 for exactly 8 baud ticks (start bit plus seven zero data bits of 0x80) and then goes to 1.
- R3: After the eight dominant bits, `tx_line` stays 1 and `wake_tx_busy` stays 1 for 1 + `delim_len` baud ticks: the stop bit, then the delimiter. After that `wake_tx_busy` falls. The value of `delim_len` is sampled when the stop bit ends.
- R4: A trigger write while `wake_tx_busy` is 1 is ignored. The frame in progress keeps its length, and no second frame follows.
- R5: A received character with value 0x00, 0x80 or 0xC0 (`rx_char_valid` high) arms the detector (`stat_rx_act` = 1). Zero or more baud ticks may then sample `rx_line` = 0. The first baud tick that samples `rx_line` = 1 sets `wake_flag`, and the flag is visible one clock after that tick. It is not set earlier.
- R6: Any other character value, for example 0x40, 0x81 or 0xFF, does not arm the detector and does not set `wake_flag`. A non-qualifying character received while the detector is armed disarms it.
- R7: While `frame_active` is 1, no qualifying character arms the detector. If `frame_active` rises during the pattern, the detector disarms and the pattern sets no flag.
- R8: `wake_flag` stays 1 until a write of 1 on `wake_clr_wr` clears it. If that write arrives in the same cycle as a new set, the flag ends up 1.
- R9: While `proto_rst` is 1, from the next clock `tx_line` is 1 and `wake_tx_busy` is 0. A frame in progress is abandoned, the detector disarms, and trigger writes are ignored.
- R10: While `proto_rst` is 1, from the next clock `rx_dma_req`, `tx_dma_req`, `stat_dma_act`, `stat_tx_act` and `stat_rx_act` are 0. `stat_lin_act` is 0 at once. When reset is not held, each DMA request follows its source with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at each bit boundary |
| proto_rst | input | 1 | Protocol engine stop and reset, level |
| wake_trig_wr | input | 1 | Write of 1 to the wake-up trigger |
| wake_clr_wr | input | 1 | Write of 1 to clear the wake-up flag |
| delim_len | input | DELIM_W | Delimiter length in bit times |
| tx_line | output | 1 | LIN transmit line, 1 = recessive |
| rx_line | input | 1 | Raw LIN receive line |
| rx_char_valid | input | 1 | Received character strobe from the bit engine |
| rx_char | input | 8 | Received character value |
| frame_active | input | 1 | A LIN frame is starting or running |
| rx_dma_src | input | 1 | Receive DMA request from the bit engine |
| tx_dma_src | input | 1 | Transmit DMA request from the bit engine |
| rx_dma_req | output | 1 | Gated receive DMA request |
| tx_dma_req | output | 1 | Gated transmit DMA request |
| wake_flag | output | 1 | Sticky wake-up detected flag |
| wake_tx_busy | output | 1 | Wake-up frame is being sent |
| stat_dma_act | output | 1 | A DMA request is active |
| stat_lin_act | output | 1 | LIN frame activity seen by the block |
| stat_tx_act | output | 1 | Transmitter activity |
| stat_rx_act | output | 1 | Receiver activity (detector armed or RX DMA) |

## Verification
A transmit counter stuck or off by one changes how many baud ticks the line stays dominant or recessive. The error shows on `tx_line` within one frame, at the edge where `wake_tx_busy` falls. A detector stuck armed or stuck idle shows on `stat_rx_act` one clock after the character strobe. It also shows on `wake_flag` at the first tick that samples a recessive line. A wrong reset path shows within one clock of `proto_rst`, as a dominant line, a busy transmitter or a DMA request that stays high.

// File: rtl/lwk_pkg.sv
package lwk_pkg;

    localparam int CHAR_W   = 8;
    localparam int BITCNT_W = $clog2(CHAR_W + 1);

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_CHAR  = 2'd1,
        TX_DELIM = 2'd2
    } tx_st_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_ARMED = 1'b1
    } rx_st_e;

    // Accepted values are 0x00, 0x80 and 0xC0: low six bits clear, and not 0x40.
    function automatic logic is_wake_char(input logic [CHAR_W-1:0] c);
        return (c[CHAR_W-3:0] == '0) && !(!c[CHAR_W-1] && c[CHAR_W-2]);
    endfunction

endpackage

// File: rtl/lwk_tx_gen.sv
module lwk_tx_gen
    import lwk_pkg::*;
#(
    parameter int DELIM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               proto_rst,
    input  logic               trig,
    input  logic [DELIM_W-1:0] delim_len,
    output logic               tx_line,
    output logic               busy
);

    localparam logic [BITCNT_W-1:0] STOP_IDX = BITCNT_W'(CHAR_W);

    typedef struct packed {
        tx_st_e              st;
        logic [BITCNT_W-1:0] bitc;
        logic [DELIM_W-1:0]  dcnt;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (proto_rst) begin
            s_d.st   = TX_IDLE;
            s_d.bitc = '0;
            s_d.dcnt = '0;
        end else begin
            unique case (s_q.st)
                TX_IDLE: begin
                    if (trig) begin
                        s_d.st   = TX_CHAR;
                        s_d.bitc = '0;
                    end
                end
                TX_CHAR: begin
                    if (baud_tick) begin
                        if (s_q.bitc == STOP_IDX) begin
                            s_d.bitc = '0;
                            if (delim_len == '0) begin
                                s_d.st = TX_IDLE;
                            end else begin
                                s_d.st   = TX_DELIM;
                                s_d.dcnt = delim_len;
                            end
                        end else begin
                            s_d.bitc = s_q.bitc + 1'b1;
                        end
                    end
                end
                TX_DELIM: begin
                    if (baud_tick) begin
                        if (s_q.dcnt <= DELIM_W'(1)) begin
                            s_d.st   = TX_IDLE;
                            s_d.dcnt = '0;
                        end else begin
                            s_d.dcnt = s_q.dcnt - 1'b1;
                        end
                    end
                end
                default: s_d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: TX_IDLE, bitc: '0, dcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_line = !((s_q.st == TX_CHAR) && (s_q.bitc < STOP_IDX));
    assign busy    = (s_q.st != TX_IDLE);

endmodule

// File: rtl/lwk_rx_detect.sv
module lwk_rx_detect
    import lwk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              proto_rst,
    input  logic              frame_active,
    input  logic              rx_line,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_val,
    output logic              armed,
    output logic              hit
);

    typedef struct packed {
        rx_st_e st;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      qual;

    always_comb begin
        qual = char_valid && is_wake_char(char_val);
        hit  = (s_q.st == RX_ARMED) && baud_tick && rx_line
               && !frame_active && !proto_rst;
        s_d  = s_q;
        if (proto_rst || frame_active) begin
            s_d.st = RX_IDLE;
        end else begin
            unique case (s_q.st)
                RX_IDLE: begin
                    if (qual) s_d.st = RX_ARMED;
                end
                RX_ARMED: begin
                    if (hit) begin
                        s_d.st = RX_IDLE;
                    end else if (char_valid && !qual) begin
                        s_d.st = RX_IDLE;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RX_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign armed = (s_q.st == RX_ARMED);

endmodule

// File: rtl/lin_wake_ctrl.sv
module lin_wake_ctrl
    import lwk_pkg::*;
#(
    parameter int DELIM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               proto_rst,
    input  logic               wake_trig_wr,
    input  logic               wake_clr_wr,
    input  logic [DELIM_W-1:0] delim_len,
    output logic               tx_line,
    input  logic               rx_line,
    input  logic               rx_char_valid,
    input  logic [7:0]         rx_char,
    input  logic               frame_active,
    input  logic               rx_dma_src,
    input  logic               tx_dma_src,
    output logic               rx_dma_req,
    output logic               tx_dma_req,
    output logic               wake_flag,
    output logic               wake_tx_busy,
    output logic               stat_dma_act,
    output logic               stat_lin_act,
    output logic               stat_tx_act,
    output logic               stat_rx_act
);

    typedef struct packed {
        logic flag;
        logic rx_dma;
        logic tx_dma;
    } top_state_t;

    top_state_t s_d, s_q;
    logic       tx_busy;
    logic       rx_armed;
    logic       rx_hit;

    lwk_tx_gen #(.DELIM_W(DELIM_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .proto_rst (proto_rst),
        .trig      (wake_trig_wr),
        .delim_len (delim_len),
        .tx_line   (tx_line),
        .busy      (tx_busy)
    );

    lwk_rx_detect u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .proto_rst    (proto_rst),
        .frame_active (frame_active),
        .rx_line      (rx_line),
        .char_valid   (rx_char_valid),
        .char_val     (rx_char),
        .armed        (rx_armed),
        .hit          (rx_hit)
    );

    always_comb begin
        s_d = s_q;
        if (wake_clr_wr) s_d.flag = 1'b0;
        if (rx_hit)      s_d.flag = 1'b1;
        s_d.rx_dma = rx_dma_src && !proto_rst;
        s_d.tx_dma = tx_dma_src && !proto_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wake_flag    = s_q.flag;
    assign rx_dma_req   = s_q.rx_dma;
    assign tx_dma_req   = s_q.tx_dma;
    assign wake_tx_busy = tx_busy;
    assign stat_dma_act = s_q.rx_dma || s_q.tx_dma;
    assign stat_lin_act = frame_active && !proto_rst;
    assign stat_tx_act  = tx_busy || s_q.tx_dma;
    assign stat_rx_act  = rx_armed || s_q.rx_dma;

endmodule

// File: rtl/lin_wake_ctrl_chk.sv
module lin_wake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic proto_rst,
    input logic wake_clr_wr,
    input logic frame_active,
    input logic rx_line,
    input logic tx_line,
    input logic wake_tx_busy,
    input logic wake_flag,
    input logic rx_armed,
    input logic rx_dma_req,
    input logic tx_dma_req
);

    assert_line_recessive_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_tx_busy |-> tx_line);

    assert_flag_after_high_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> ($past(rx_armed) && $past(baud_tick) && $past(rx_line)));

    assert_frame_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active |=> !rx_armed);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !wake_clr_wr) |=> wake_flag);

    assert_reset_stops_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_rst |=> (tx_line && !wake_tx_busy && !rx_armed));

    assert_reset_drops_dma_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_rst |=> (!rx_dma_req && !tx_dma_req));

endmodule

bind lin_wake_ctrl lin_wake_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_tick    (baud_tick),
    .proto_rst    (proto_rst),
    .wake_clr_wr  (wake_clr_wr),
    .frame_active (frame_active),
    .rx_line      (rx_line),
    .tx_line      (tx_line),
    .wake_tx_busy (wake_tx_busy),
    .wake_flag    (wake_flag),
    .rx_armed     (rx_armed),
    .rx_dma_req   (rx_dma_req),
    .tx_dma_req   (tx_dma_req)
);

// File: tb/sim_lin_wake_ctrl.sv
module sim_lin_wake_ctrl;

    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic proto_rst = 1'b0;
    logic wake_trig_wr = 1'b0;
    logic wake_clr_wr = 1'b0;
    logic [DW-1:0] delim_len = '0;
    logic rx_line = 1'b0;
    logic rx_char_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic frame_active = 1'b0;
    logic rx_dma_src = 1'b0;
    logic tx_dma_src = 1'b0;
    logic tx_line, rx_dma_req, tx_dma_req, wake_flag, wake_tx_busy;
    logic stat_dma_act, stat_lin_act, stat_tx_act, stat_rx_act;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_skip = 1'b0;
    bit finished = 1'b0;
    int tick_ctr = 0;

    typedef struct {
        int req;
        int low;
        int high;
    } frame_exp_t;
    frame_exp_t exp_q[$];

    always #5 clk = ~clk;

    lin_wake_ctrl #(.DELIM_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .proto_rst(proto_rst),
        .wake_trig_wr(wake_trig_wr), .wake_clr_wr(wake_clr_wr), .delim_len(delim_len),
        .tx_line(tx_line), .rx_line(rx_line), .rx_char_valid(rx_char_valid),
        .rx_char(rx_char), .frame_active(frame_active), .rx_dma_src(rx_dma_src),
        .tx_dma_src(tx_dma_src), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .wake_flag(wake_flag), .wake_tx_busy(wake_tx_busy), .stat_dma_act(stat_dma_act),
        .stat_lin_act(stat_lin_act), .stat_tx_act(stat_tx_act), .stat_rx_act(stat_rx_act)
    );

    // baud tick: one cycle in four, changed at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            tick_ctr++;
            baud_tick = (tick_ctr % 4 == 0);
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // monitor: measures each wake-up frame on tx_line in baud ticks and compares
    initial begin
        logic prev_busy;
        logic prev_line;
        int   lo;
        int   hi;
        prev_busy = 1'b0; prev_line = 1'b1; lo = 0; hi = 0;
        forever begin
            @(posedge clk);
            #1;
            if (prev_busy && baud_tick) begin
                if (prev_line == 1'b0) lo++;
                else hi++;
            end
            if (prev_busy && !wake_tx_busy) begin
                if (mon_skip) begin
                    lo = 0; hi = 0;
                end else if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R4 unexpected frame: actual low %0d high %0d expected none", lo, hi);
                end else begin
                    frame_exp_t e;
                    e = exp_q.pop_front();
                    n_chk++;
                    if (lo != e.low) begin
                        n_bad++;
                        $display("FAIL R%0d dominant ticks: actual %0d expected %0d", e.req, lo, e.low);
                    end
                    n_chk++;
                    if (hi != e.high) begin
                        n_bad++;
                        $display("FAIL R%0d recessive ticks: actual %0d expected %0d", e.req, hi, e.high);
                    end
                end
                lo = 0; hi = 0;
            end
            prev_busy = wake_tx_busy;
            prev_line = tx_line;
        end
    end

    task automatic send_wake(input int d, input int req);
        frame_exp_t e;
        @(negedge clk);
        delim_len = DW'(d);
        wake_trig_wr = 1'b1;
        e.req = req; e.low = 8; e.high = 1 + d;
        exp_q.push_back(e);
        @(negedge clk);
        wake_trig_wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (wake_tx_busy) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_tick_edge();
        forever begin
            @(posedge clk);
            if (baud_tick) break;
        end
        #1;
    endtask

    task automatic give_char(input logic [7:0] c);
        @(negedge clk);
        rx_char = c; rx_char_valid = 1'b1;
        @(negedge clk);
        rx_char_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); wake_clr_wr = 1'b1;
        @(negedge clk); wake_clr_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check("R1", tx_line, 1'b1, "tx_line");
        check("R1", wake_flag, 1'b0, "wake_flag");
        check("R1", wake_tx_busy, 1'b0, "busy");
        check("R1", rx_dma_req | tx_dma_req, 1'b0, "dma");
        check("R1", stat_dma_act | stat_lin_act | stat_tx_act | stat_rx_act, 1'b0, "status");

        // R2 / R3 frames with several delimiter lengths
        send_wake(3, 2);
        @(posedge clk); #1;
        check("R2", tx_line, 1'b0, "line dominant after trigger");
        wait_idle();
        send_wake(0, 3);
        wait_idle();
        send_wake(15, 3);
        wait_idle();

        // R4 trigger while busy ignored
        send_wake(2, 4);
        repeat (10) @(negedge clk);
        wake_trig_wr = 1'b1;
        @(negedge clk);
        wake_trig_wr = 1'b0;
        wait_idle();
        repeat (60) @(posedge clk);
        #1;
        check("R4", wake_tx_busy, 1'b0, "no second frame");

        // R5: 0x80, two low samples, then high
        rx_line = 1'b0;
        give_char(8'h80);
        #1;
        check("R5", stat_rx_act, 1'b1, "armed by 0x80");
        wait_tick_edge();
        wait_tick_edge();
        check("R5", wake_flag, 1'b0, "no flag on low bits");
        @(negedge clk); rx_line = 1'b1;
        wait_tick_edge();
        check("R5", wake_flag, 1'b1, "flag on first high bit");
        check("R5", stat_rx_act, 1'b0, "detector idle after hit");

        // R8 sticky then clear
        repeat (9) @(posedge clk);
        #1;
        check("R8", wake_flag, 1'b1, "flag sticky");
        clear_flag();
        #1;
        check("R8", wake_flag, 1'b0, "flag cleared");

        // R5: 0x00 and 0xC0 with immediate high bit
        give_char(8'h00);
        wait_tick_edge();
        check("R5", wake_flag, 1'b1, "0x00 sets flag");
        clear_flag();
        give_char(8'hC0);
        wait_tick_edge();
        check("R5", wake_flag, 1'b1, "0xC0 sets flag");
        clear_flag();

        // R6 non-qualifying characters
        give_char(8'h40);
        #1; check("R6", stat_rx_act, 1'b0, "0x40 not armed");
        give_char(8'h81);
        #1; check("R6", stat_rx_act, 1'b0, "0x81 not armed");
        give_char(8'hFF);
        wait_tick_edge(); wait_tick_edge();
        check("R6", wake_flag, 1'b0, "no flag from 0xFF");
        rx_line = 1'b0;
        give_char(8'h80);
        give_char(8'h55);
        #1; check("R6", stat_rx_act, 1'b0, "disarmed by other char");
        @(negedge clk); rx_line = 1'b1;
        wait_tick_edge(); wait_tick_edge();
        check("R6", wake_flag, 1'b0, "no flag after disarm");

        // R7 frame activity suppresses
        @(negedge clk); rx_line = 1'b0; frame_active = 1'b1;
        give_char(8'h80);
        #1; check("R7", stat_rx_act, 1'b0, "not armed during frame");
        @(negedge clk); frame_active = 1'b0;
        give_char(8'h00);
        @(negedge clk); frame_active = 1'b1;
        @(negedge clk); frame_active = 1'b0; rx_line = 1'b1;
        wait_tick_edge(); wait_tick_edge();
        check("R7", wake_flag, 1'b0, "pattern aborted by frame");

        // R8 clear in the same cycle as set leaves flag set
        rx_line = 1'b0;
        give_char(8'h80);
        @(negedge clk); rx_line = 1'b1;
        wait_tick_edge();
        clear_flag();
        #1; check("R8", wake_flag, 1'b0, "cleared before race");
        rx_line = 1'b0;
        give_char(8'hC0);
        @(negedge clk); rx_line = 1'b1;
        wait_tick_edge();
        clear_flag();
        #1; check("R8", wake_flag, 1'b0, "flag cleared before race");
        rx_line = 1'b0;
        give_char(8'h80);
        wait_tick_edge();
        rx_line = 1'b1;
        repeat (3) @(posedge clk);
        #2; wake_clr_wr = 1'b1;
        @(posedge clk); #1;
        check("R8", baud_tick, 1'b1, "race aligned to tick");
        wake_clr_wr = 1'b0;
        check("R8", wake_flag, 1'b1, "set wins over clear");
        clear_flag();

        // R10 DMA passthrough outside reset
        @(negedge clk); rx_dma_src = 1'b1; tx_dma_src = 1'b1;
        @(posedge clk); #1;
        check("R10", rx_dma_req & tx_dma_req, 1'b1, "dma follows source");
        check("R10", stat_dma_act, 1'b1, "dma status");

        // R9 / R10 protocol reset during activity
        mon_skip = 1'b1;
        @(negedge clk); rx_line = 1'b0;
        wake_trig_wr = 1'b1; rx_char = 8'h80; rx_char_valid = 1'b1;
        @(negedge clk); wake_trig_wr = 1'b0; rx_char_valid = 1'b0;
        #1; check("R9", wake_tx_busy, 1'b1, "frame running before reset");
        @(negedge clk); frame_active = 1'b1; proto_rst = 1'b1;
        #1; check("R10", stat_lin_act, 1'b0, "lin status gated");
        @(posedge clk); #1;
        check("R9", tx_line, 1'b1, "line recessive");
        check("R9", wake_tx_busy, 1'b0, "busy dropped");
        check("R10", rx_dma_req | tx_dma_req, 1'b0, "dma dropped");
        check("R10", stat_dma_act | stat_tx_act | stat_rx_act, 1'b0, "activity idle");
        @(negedge clk); frame_active = 1'b0; wake_trig_wr = 1'b1;
        @(negedge clk); wake_trig_wr = 1'b0;
        #1; check("R9", wake_tx_busy, 1'b0, "trigger ignored in reset");
        check("R9", tx_line, 1'b1, "line held recessive");
        @(negedge clk); proto_rst = 1'b0; rx_dma_src = 1'b0; tx_dma_src = 1'b0;
        repeat (4) @(posedge clk);
        mon_skip = 1'b0;

        // R2 frame after reset release
        send_wake(1, 2);
        wait_idle();
        repeat (4) @(posedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R3 frames outstanding: actual %0d expected 0", exp_q.size());
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule